// File: doc/BRIEF.md
# Power and Mode Sequencer for an Audio Converter

This block sets the power state and the operating options of an audio converter from two slow control levels: an enable request and a dual-purpose emphasis/mode line. It runs on a free-running reference clock. It also watches the converter's master clock, which comes from a separate and possibly stopped clock domain. Power-up happens only when the enable line goes from low to high. If the enable line is already high when reset ends, the block stays off.

The mode line has two jobs. At the moment the enable line rises, its level is stored as the high-performance option, and that stored value does not change until the next rising edge. While the converter is powered, the same line selects de-emphasis directly. A toggle flop in the master-clock domain shows whether that clock is running. When no toggle has been seen for a programmed number of reference cycles, the block leaves the powered state and raises a power-down request. It powers up again by itself when the clock comes back, as long as enable is still high.

Top module: `pwr_mode_seq`

## Requirements
- R1: During reset and on the first cycle after it, pwr_up, hiperf, deemph_on and pd_req are all 0.
- R2: If en_req is high during reset and stays high, pwr_up remains 0, because no rising edge has occurred.
- R3: With the master clock running, a low-to-high change of en_req applied between clock edges sets pwr_up to 1 at the third rising edge of ref_clk, and not before.
- R4: At each rising edge of en_req, hiperf takes the level of mode_sel (1 = high-performance). It then holds that value through later mode_sel changes and through en_req going low, until the next rising edge.
- R5: While pwr_up is 1, deemph_on equals mode_sel, with the new value appearing at the third rising ref_clk edge after a change. While pwr_up is 0, deemph_on is 0.
- R6: When en_req is low for more than three ref_clk cycles, pwr_up and pd_req are both 0, whether the block was powered or in clock-loss power-down.
- R7: While the block is enabled, if mclk stops toggling, pd_req goes to 1 and pwr_up goes to 0 after about TMO_EFF reference cycles (within two cycles below and six cycles above). TMO_EFF is TMO_CYC clamped into the range [TMO_MIN, TMO_MAX]. pwr_up and pd_req are never 1 at the same time.
- R8: If mclk starts toggling again while en_req is still high, pd_req returns to 0 and pwr_up returns to 1 without a new rising edge of en_req.
- R9: Every observed mclk toggle restarts the timeout. An mclk whose period is shorter than TMO_EFF reference cycles never raises pd_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk | input | 1 | Converter master clock, watched for activity |
| en_req | input | 1 | Asynchronous enable level; its rising edge powers up |
| mode_sel | input | 1 | Asynchronous line: performance option at power-up, de-emphasis select afterwards |
| pwr_up | output | 1 | Converter powered and running |
| hiperf | output | 1 | High-performance option stored at the last enable rising edge |
| deemph_on | output | 1 | De-emphasis filter select |
| pd_req | output | 1 | Power-down request because the master clock stopped |

## Verification
The bench builds the block with TMO_CYC of 48, TMO_MIN of 24 and TMO_MAX of 192, so the effective timeout is 48 reference cycles. That is short enough to measure the entry into clock-loss power-down several times in one run. It is also long enough that a master clock slowed to a 30-cycle period still counts as running. The master clock runs asynchronously to the 100 MHz reference, with a period of 14 ns in normal operation. This exercises the synchroniser path with non-aligned toggles, along with stop, restart and slow-clock phases.

// File: rtl/pms_pkg.sv
`timescale 1ns/1ps
package pms_pkg;

    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_ON    = 2'd1,
        PS_SLEEP = 2'd2
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e st;
        logic       en_prev;
        logic       hiperf;
        logic       deemph;
    } ctrl_regs_t;

    function automatic int unsigned clamp_tmo(int unsigned req, int unsigned lo, int unsigned hi);
        if (req < lo) return lo;
        if (req > hi) return hi;
        return req;
    endfunction

endpackage

// File: rtl/pms_sync.sv
`timescale 1ns/1ps
module pms_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/pms_mclk_mon.sv
`timescale 1ns/1ps
module pms_mclk_mon #(
    parameter int unsigned TMO    = 48,
    parameter int          SYNC_N = 2
) (
    input  logic ref_clk,
    input  logic mclk,
    input  logic rst_n,
    output logic clk_dead,
    output logic toggle_seen
);
    localparam int CNT_W = $clog2(TMO + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(TMO);

    typedef struct packed {
        logic             last;
        logic [CNT_W-1:0] cnt;
    } mon_regs_t;

    // master-clock domain toggle flop
    logic tgl_d, tgl_q;
    always_comb tgl_d = ~tgl_q;
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= tgl_d;
    end

    logic tgl_s;
    pms_sync #(.W(1), .STAGES(SYNC_N), .RST_VAL(1'b0)) u_tgl_sync (
        .clk  (ref_clk),
        .rst_n(rst_n),
        .din  (tgl_q),
        .dout (tgl_s)
    );

    mon_regs_t m_d, m_q;
    logic      seen;

    always_comb begin
        m_d      = m_q;
        seen     = tgl_s ^ m_q.last;
        m_d.last = tgl_s;
        if (seen)                 m_d.cnt = '0;
        else if (m_q.cnt != CNT_TOP) m_d.cnt = m_q.cnt + 1'b1;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign clk_dead    = (m_q.cnt == CNT_TOP);
    assign toggle_seen = seen;

    AST_CNT_BOUNDED: assert property (@(posedge ref_clk) disable iff (!rst_n)
        m_q.cnt <= CNT_TOP);  // R7
    AST_DEAD_AFTER_QUIET: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(clk_dead) |-> !$past(toggle_seen));  // R9
    AST_TOGGLE_REVIVES: assert property (@(posedge ref_clk) disable iff (!rst_n)
        toggle_seen |=> !clk_dead);  // R9
endmodule

// File: rtl/pms_ctrl.sv
`timescale 1ns/1ps
module pms_ctrl
    import pms_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_s,
    input  logic mode_s,
    input  logic clk_dead,
    output logic pwr_up,
    output logic hiperf,
    output logic deemph_on,
    output logic pd_req
);
    ctrl_regs_t r_d, r_q;
    logic       rise;

    always_comb begin
        r_d        = r_q;
        rise       = en_s & ~r_q.en_prev;
        r_d.en_prev = en_s;
        if (rise) r_d.hiperf = mode_s;
        unique case (r_q.st)
            PS_OFF:   if (rise) r_d.st = PS_ON;
            PS_ON:    if (!en_s) r_d.st = PS_OFF;
                      else if (clk_dead) r_d.st = PS_SLEEP;
            PS_SLEEP: if (!en_s) r_d.st = PS_OFF;
                      else if (!clk_dead) r_d.st = PS_ON;
            default:  r_d.st = PS_OFF;
        endcase
        r_d.deemph = (r_d.st == PS_ON) & mode_s;
    end

    // en_prev resets high so a level already high at reset is not an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: PS_OFF, en_prev: 1'b1, hiperf: 1'b0, deemph: 1'b0};
        else        r_q <= r_d;
    end

    assign pwr_up    = (r_q.st == PS_ON);
    assign pd_req    = (r_q.st == PS_SLEEP);
    assign hiperf    = r_q.hiperf;
    assign deemph_on = r_q.deemph;

    AST_POWER_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PS_ON) && $past(r_q.st == PS_OFF) |-> $past(en_s) && !$past(r_q.en_prev));  // R2
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rise) |-> $stable(r_q.hiperf));  // R4
    AST_EMPH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        deemph_on |-> pwr_up);  // R5
    AST_OFF_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> (r_q.st == PS_OFF));  // R6
    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PS_ON) && en_s && clk_dead |=> pd_req);  // R7
    AST_WAKE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PS_SLEEP) && en_s && !clk_dead |=> pwr_up);  // R8
endmodule

// File: rtl/pwr_mode_seq.sv
`timescale 1ns/1ps
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int unsigned TMO_CYC = 48,
    parameter int unsigned TMO_MIN = 24,
    parameter int unsigned TMO_MAX = 192,
    parameter int          SYNC_N  = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mclk,
    input  logic en_req,
    input  logic mode_sel,
    output logic pwr_up,
    output logic hiperf,
    output logic deemph_on,
    output logic pd_req
);
    localparam int unsigned TMO_EFF = clamp_tmo(TMO_CYC, TMO_MIN, TMO_MAX);

    logic [1:0] pins_s;
    logic       dead, seen;

    // bit0 enable resets high, bit1 mode line resets low
    pms_sync #(.W(2), .STAGES(SYNC_N), .RST_VAL(2'b01)) u_pin_sync (
        .clk  (ref_clk),
        .rst_n(rst_n),
        .din  ({mode_sel, en_req}),
        .dout (pins_s)
    );

    pms_mclk_mon #(.TMO(TMO_EFF), .SYNC_N(SYNC_N)) u_mon (
        .ref_clk    (ref_clk),
        .mclk       (mclk),
        .rst_n      (rst_n),
        .clk_dead   (dead),
        .toggle_seen(seen)
    );

    pms_ctrl u_ctrl (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .en_s     (pins_s[0]),
        .mode_s   (pins_s[1]),
        .clk_dead (dead),
        .pwr_up   (pwr_up),
        .hiperf   (hiperf),
        .deemph_on(deemph_on),
        .pd_req   (pd_req)
    );

    AST_STATES_EXCLUSIVE: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(pwr_up && pd_req) && !(deemph_on && pd_req));  // R7
endmodule

// File: tb/pwr_mode_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_seq_tb_top;
    localparam int unsigned TMO_CYC = 48;
    localparam int unsigned TMO_MIN = 24;
    localparam int unsigned TMO_MAX = 192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclk = 1'b0;
    logic en_req = 1'b1;
    logic mode_sel = 1'b0;
    logic pwr_up, hiperf, deemph_on, pd_req;
    bit   mclk_run = 1'b1;
    int   mhalf = 7;
    int   checks = 0;
    int   errors = 0;

    always #5 clk = ~clk;
    always begin
        #(mhalf);
        if (mclk_run) mclk = ~mclk;
    end

    pwr_mode_seq #(.TMO_CYC(TMO_CYC), .TMO_MIN(TMO_MIN), .TMO_MAX(TMO_MAX)) dut_i (
        .ref_clk  (clk),
        .rst_n    (rst_n),
        .mclk     (mclk),
        .en_req   (en_req),
        .mode_sel (mode_sel),
        .pwr_up   (pwr_up),
        .hiperf   (hiperf),
        .deemph_on(deemph_on),
        .pd_req   (pd_req)
    );

    function automatic int eff_tmo();
        if (TMO_CYC < TMO_MIN) return TMO_MIN;
        if (TMO_CYC > TMO_MAX) return TMO_MAX;
        return TMO_CYC;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(string req, int act, int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic wait_pd(output int n);
        n = 0;
        while (!pd_req && n < 400) begin
            tick(1);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        bit en_m, mode_m, on_m, hi_m, saw_pd;
        void'($urandom(32'h1a2b3c4d));
        tick(5);
        chk_eq("R1 pwr_up in reset", pwr_up, 0);
        chk_eq("R1 pd_req in reset", pd_req, 0);
        rst_n = 1'b1;
        tick(1);
        chk_eq("R1 outputs after reset", {pwr_up, hiperf, deemph_on, pd_req}, 0);
        tick(10);
        chk_eq("R2 enable high from reset", pwr_up, 0);

        en_req = 1'b0;
        tick(6);
        chk_eq("R6 enable low", pwr_up, 0);
        mode_sel = 1'b1;
        tick(6);
        chk_eq("R5 deemph while off", deemph_on, 0);

        en_req = 1'b1;
        tick(2);
        chk_eq("R3 not yet powered", pwr_up, 0);
        tick(1);
        chk_eq("R3 powered on third edge", pwr_up, 1);
        chk_eq("R4 hiperf captured high", hiperf, 1);
        tick(3);
        chk_eq("R5 deemph follows high", deemph_on, 1);
        mode_sel = 1'b0;
        tick(2);
        chk_eq("R5 deemph before latency", deemph_on, 1);
        tick(1);
        chk_eq("R5 deemph after latency", deemph_on, 0);
        chk_eq("R4 hiperf held after mode change", hiperf, 1);

        en_req = 1'b0;
        tick(6);
        chk_eq("R6 powered off", pwr_up, 0);
        chk_eq("R4 hiperf held while off", hiperf, 1);
        en_req = 1'b1;
        tick(6);
        chk_eq("R4 hiperf recaptured low", hiperf, 0);
        chk_eq("R3 powered again", pwr_up, 1);

        mclk_run = 1'b0;
        wait_pd(n);
        chk((n >= eff_tmo() - 2) && (n <= eff_tmo() + 6), "R7 timeout length", n, eff_tmo());
        chk_eq("R7 pwr_up dropped", pwr_up, 0);
        mclk_run = 1'b1;
        tick(8);
        chk_eq("R8 resumed pwr_up", pwr_up, 1);
        chk_eq("R8 pd_req cleared", pd_req, 0);

        mhalf = 150;
        tick(40);
        saw_pd = 1'b0;
        for (int i = 0; i < 400; i++) begin
            tick(1);
            if (pd_req) saw_pd = 1'b1;
        end
        chk_eq("R9 slow clock keeps power", saw_pd, 0);
        chk_eq("R9 still powered", pwr_up, 1);
        mhalf = 7;

        mclk_run = 1'b0;
        wait_pd(n);
        chk_eq("R7 second power-down", pd_req, 1);
        en_req = 1'b0;
        tick(6);
        chk_eq("R6 leaves clock-loss state", {pwr_up, pd_req}, 0);
        mclk_run = 1'b1;
        tick(10);
        chk_eq("R6 stays off with clock back", pwr_up, 0);

        en_m = 1'b0; mode_m = 1'b0; on_m = 1'b0; hi_m = 1'b0;
        mode_sel = 1'b0;
        tick(6);
        for (int s = 0; s < 300; s++) begin
            if ($urandom % 2 == 0) begin
                if (!en_m) begin
                    on_m = 1'b1;
                    hi_m = mode_m;
                end else begin
                    on_m = 1'b0;
                end
                en_m = ~en_m;
                en_req = en_m;
            end else begin
                mode_m = ~mode_m;
                mode_sel = mode_m;
            end
            tick(4 + ($urandom % 4));
            chk_eq("R3 random pwr_up", pwr_up, int'(on_m));
            chk_eq("R4 random hiperf", hiperf, int'(hi_m));
            chk_eq("R5 random deemph", deemph_on, int'(on_m & mode_m));
            chk_eq("R7 random pd_req", pd_req, 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule